// File: doc/BRIEF.md
# Subset Integer ALU with Immediate Operands

This block is the combinational arithmetic and logic stage of a small RISC integer pipeline. Each cycle the execute stage presents two register values, the 16-bit immediate field, the 6-bit primary opcode and the 6-bit function code of the current instruction. The unit decodes the operation from the opcode and, for register-register instructions, the function code. It then picks the second operand from the register value or the immediate, extended as the instruction class requires, and returns a 32-bit result.

Alongside the result it gives two branch flags taken straight from the register operands: whether they are equal, and whether the first one is negative. These serve the equal, not-equal and less-than-zero branches. A pair of opcode and function code that is not supported returns zero and raises an illegal-operation flag, so that the control logic can trap. There is no storage: every output follows the inputs in the same cycle.

Top module: `subset_alu`

## Requirements
- R1: With opcode 0 and function 32, the result is rs + rt mod 2^32. With opcode 8 the result is rs plus the sign-extended immediate. Both wrap with no exception.
- R2: With opcode 0 and function 34, the result is rs - rt mod 2^32.
- R3: Function 42 with opcode 0 compares rs with rt. Opcode 10 compares rs with the sign-extended immediate. The comparison is signed two's complement, and the result is 1 when rs is smaller and 0 otherwise, even where rs - rt overflows.
- R4: With opcode 0, functions 36, 37, 38 and 39 give the bitwise AND, OR, XOR and NOR of rs and rt. A NOR of zero with zero gives 0xffffffff.
- R5: Opcodes 12, 13 and 14 give the AND, OR and XOR of rs with the immediate zero-extended to 32 bits.
- R6: Opcodes 8 and 10 sign-extend the immediate, so 0x8000 acts as -32768 and 0x7fff acts as 32767.
- R7: Opcode 15 gives the immediate in bits 31..16 and zeros in bits 15..0, whatever the value of rs.
- R8: Any other opcode, or opcode 0 with a function code not listed in R1 to R4, gives a result of 0 with illegal_o high. illegal_o is low for every listed operation.
- R9: eq_o is 1 exactly when rs equals rt, for every opcode.
- R10: neg_o equals bit 31 of rs, for every opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Primary opcode |
| funct_i | input | 6 | Function code, used when opcode is 0 |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Operation result |
| eq_o | output | 1 | rs equals rt |
| neg_o | output | 1 | rs is negative |
| illegal_o | output | 1 | Unsupported opcode/function pair |

## Verification
The unit holds no state, so an internal fault shows at the ports as soon as the inputs settle, on the same vector that exercises it. A wrong decode, such as the wrong extension or operand select, shows up as a wrong result only for operands that tell the variants apart. Examples are immediates with bit 15 set and comparisons whose subtraction overflows, and the directed cases target exactly these. Random vectors over the legal and illegal encodings cover the rest of the decode space.

// File: rtl/subset_alu_pkg.sv
package subset_alu_pkg;
  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'd14;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

  localparam logic [OPC_W-1:0] FN_ADD = 6'd32;
  localparam logic [OPC_W-1:0] FN_SUB = 6'd34;
  localparam logic [OPC_W-1:0] FN_AND = 6'd36;
  localparam logic [OPC_W-1:0] FN_OR  = 6'd37;
  localparam logic [OPC_W-1:0] FN_XOR = 6'd38;
  localparam logic [OPC_W-1:0] FN_NOR = 6'd39;
  localparam logic [OPC_W-1:0] FN_SLT = 6'd42;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_LUI, ALU_NONE
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG, SRC_SEXT, SRC_ZEXT
  } src_sel_e;
endpackage

// File: rtl/subset_alu_dec.sv
module subset_alu_dec
  import subset_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [OPC_W-1:0] funct_i,
  output alu_op_e          op_o,
  output src_sel_e         src_o,
  output logic             illegal_o
);
  always_comb begin
    op_o      = ALU_NONE;
    src_o     = SRC_REG;
    illegal_o = 1'b0;
    unique case (opcode_i)
      OPC_RTYPE: begin
        unique case (funct_i)
          FN_ADD:  op_o = ALU_ADD;
          FN_SUB:  op_o = ALU_SUB;
          FN_AND:  op_o = ALU_AND;
          FN_OR:   op_o = ALU_OR;
          FN_XOR:  op_o = ALU_XOR;
          FN_NOR:  op_o = ALU_NOR;
          FN_SLT:  op_o = ALU_SLT;
          default: illegal_o = 1'b1;
        endcase
      end
      OPC_ADDI: begin op_o = ALU_ADD; src_o = SRC_SEXT; end
      OPC_SLTI: begin op_o = ALU_SLT; src_o = SRC_SEXT; end
      OPC_ANDI: begin op_o = ALU_AND; src_o = SRC_ZEXT; end
      OPC_ORI:  begin op_o = ALU_OR;  src_o = SRC_ZEXT; end
      OPC_XORI: begin op_o = ALU_XOR; src_o = SRC_ZEXT; end
      OPC_LUI:  op_o = ALU_LUI;
      default:  illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/subset_alu_opnd.sv
module subset_alu_opnd
  import subset_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  src_sel_e          src_i,
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] opnd_b_o
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sext, imm_zext;
  assign imm_sext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign imm_zext = {{EXT_W{1'b0}}, imm_i};

  always_comb begin
    unique case (src_i)
      SRC_SEXT: opnd_b_o = imm_sext;
      SRC_ZEXT: opnd_b_o = imm_zext;
      default:  opnd_b_o = rt_val_i;
    endcase
  end
endmodule

// File: rtl/subset_alu_core.sv
module subset_alu_core
  import subset_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int LO_W = DATA_W - IMM_W;

  logic              sub_en;
  logic [DATA_W-1:0] b_inv, sum;
  logic              ovf, lt;

  // single adder shared by add, sub and slt
  assign sub_en = (op_i == ALU_SUB) || (op_i == ALU_SLT);
  assign b_inv  = sub_en ? ~b_i : b_i;
  assign sum    = a_i + b_inv + {{(DATA_W-1){1'b0}}, sub_en};
  assign ovf    = (a_i[DATA_W-1] != b_i[DATA_W-1]) && (sum[DATA_W-1] != a_i[DATA_W-1]);
  assign lt     = sum[DATA_W-1] ^ ovf;

  always_comb begin
    unique case (op_i)
      ALU_ADD, ALU_SUB: result_o = sum;
      ALU_SLT: result_o = {{(DATA_W-1){1'b0}}, lt};
      ALU_AND: result_o = a_i & b_i;
      ALU_OR:  result_o = a_i | b_i;
      ALU_XOR: result_o = a_i ^ b_i;
      ALU_NOR: result_o = ~(a_i | b_i);
      ALU_LUI: result_o = {imm_i, {LO_W{1'b0}}};
      default: result_o = '0;
    endcase
  end
endmodule

// File: rtl/subset_alu.sv
module subset_alu
  import subset_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [OPC_W-1:0]  funct_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              eq_o,
  output logic              neg_o,
  output logic              illegal_o
);
  alu_op_e           op;
  src_sel_e          src;
  logic [DATA_W-1:0] opnd_b;

  subset_alu_dec u_dec (
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .op_o     (op),
    .src_o    (src),
    .illegal_o(illegal_o)
  );

  subset_alu_opnd #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .src_i   (src),
    .rt_val_i(rt_val_i),
    .imm_i   (imm_i),
    .opnd_b_o(opnd_b)
  );

  subset_alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .op_i    (op),
    .a_i     (rs_val_i),
    .b_i     (opnd_b),
    .imm_i   (imm_i),
    .result_o(result_o)
  );

  assign eq_o  = (rs_val_i == rt_val_i);
  assign neg_o = rs_val_i[DATA_W-1];
endmodule

// File: rtl/subset_alu_chk.sv
module subset_alu_chk
  import subset_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic [OPC_W-1:0]  opcode_i,
  input logic [OPC_W-1:0]  funct_i,
  input logic [DATA_W-1:0] rs_val_i,
  input logic [DATA_W-1:0] rt_val_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic              eq_o,
  input logic              neg_o,
  input logic              illegal_o
);
  localparam int LO_W = DATA_W - IMM_W;

  always_comb begin
    if (illegal_o)
      p_illegal_zero_r8: assert (result_o == '0);
    if (opcode_i == OPC_LUI)
      p_lui_place_r7: assert (result_o == {imm_i, {LO_W{1'b0}}} && !illegal_o);
    if (opcode_i == OPC_RTYPE && funct_i == FN_SLT)
      p_slt_bool_r3: assert (result_o[DATA_W-1:1] == '0);
    if (opcode_i == OPC_RTYPE && funct_i == FN_SLT && rt_val_i == '0)
      p_slt_zero_neg_r10: assert (result_o[0] == neg_o);
    if (opcode_i == OPC_RTYPE && funct_i == FN_SUB && eq_o)
      p_sub_eq_zero_r9: assert (result_o == '0);
    if (opcode_i == OPC_ANDI || opcode_i == OPC_ORI || opcode_i == OPC_XORI)
      p_zext_upper_r5: assert (result_o[DATA_W-1:IMM_W] == rs_val_i[DATA_W-1:IMM_W] ||
                               opcode_i == OPC_ANDI);
    if (opcode_i == OPC_ANDI)
      p_andi_upper_r5: assert (result_o[DATA_W-1:IMM_W] == '0);
    if (opcode_i == OPC_RTYPE && funct_i == FN_NOR && rs_val_i == '0 && rt_val_i == '0)
      p_nor_ones_r4: assert (&result_o);
  end
endmodule

bind subset_alu subset_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .opcode_i (opcode_i),
  .funct_i  (funct_i),
  .rs_val_i (rs_val_i),
  .rt_val_i (rt_val_i),
  .imm_i    (imm_i),
  .result_o (result_o),
  .eq_o     (eq_o),
  .neg_o    (neg_o),
  .illegal_o(illegal_o)
);

// File: tb/sim_subset_alu.sv
`timescale 1ns/1ps
module sim_subset_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  opcode, funct;
  logic [31:0] rs, rt;
  logic [15:0] imm;
  logic [31:0] result;
  logic        eq, neg, illegal;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  subset_alu u0 (
    .opcode_i (opcode),
    .funct_i  (funct),
    .rs_val_i (rs),
    .rt_val_i (rt),
    .imm_i    (imm),
    .result_o (result),
    .eq_o     (eq),
    .neg_o    (neg),
    .illegal_o(illegal)
  );

  function automatic logic exp_ill(logic [5:0] op, logic [5:0] fn);
    if (op == 0) return !(fn inside {6'd32, 6'd34, 6'd36, 6'd37, 6'd38, 6'd39, 6'd42});
    return !(op inside {6'd8, 6'd10, 6'd12, 6'd13, 6'd14, 6'd15});
  endfunction

  function automatic logic [31:0] exp_res(logic [5:0] op, logic [5:0] fn,
                                          logic [31:0] a, logic [31:0] b, logic [15:0] k);
    logic [31:0] se, ze;
    se = 32'(signed'(k));
    ze = {16'h0, k};
    if (op == 0) begin
      case (fn)
        6'd32: return a + b;
        6'd34: return a - b;
        6'd36: return a & b;
        6'd37: return a | b;
        6'd38: return a ^ b;
        6'd39: return ~(a | b);
        6'd42: return {31'b0, $signed(a) < $signed(b)};
        default: return 32'h0;
      endcase
    end
    case (op)
      6'd8:  return a + se;
      6'd10: return {31'b0, $signed(a) < $signed(se)};
      6'd12: return a & ze;
      6'd13: return a | ze;
      6'd14: return a ^ ze;
      6'd15: return {k, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] op, logic [5:0] fn);
    if (exp_ill(op, fn)) return "R8";
    if (op == 0) begin
      case (fn)
        6'd32: return "R1";
        6'd34: return "R2";
        6'd42: return "R3";
        default: return "R4";
      endcase
    end
    case (op)
      6'd8, 6'd10: return "R6";
      6'd15: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(string tag, logic [5:0] op, logic [5:0] fn,
                       logic [31:0] a, logic [31:0] b, logic [15:0] k);
    logic [31:0] er;
    logic ei;
    @(negedge clk);
    opcode = op; funct = fn; rs = a; rt = b; imm = k;
    #1;
    er = exp_res(op, fn, a, b, k);
    ei = exp_ill(op, fn);
    checks++;
    if (result !== er || illegal !== ei) begin
      errors++;
      $display("FAIL %s op=%0d fn=%0d res=%h/ill=%b expected %h/%b", tag, op, fn, result, illegal, er, ei);
    end
    checks++;
    if (eq !== (a == b)) begin
      errors++;
      $display("FAIL R9 eq=%b expected %b", eq, a == b);
    end
    checks++;
    if (neg !== a[31]) begin
      errors++;
      $display("FAIL R10 neg=%b expected %b", neg, a[31]);
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] legal_op [7];
    logic [5:0] legal_fn [7];
    int unsigned seed;
    legal_op = '{6'd0, 6'd8, 6'd10, 6'd12, 6'd13, 6'd14, 6'd15};
    legal_fn = '{6'd32, 6'd34, 6'd36, 6'd37, 6'd38, 6'd39, 6'd42};
    seed = 32'd1234;
    void'($urandom(seed));
    opcode = 0; funct = 0; rs = 0; rt = 0; imm = 0;
    repeat (4) @(posedge clk);
    rst_ni = 1'b1;

    // quiescent state with all-zero inputs: opcode 0 funct 0 is illegal
    apply("R8", 6'd0, 6'd0, 32'h0, 32'h0, 16'h0);
    // directed corners
    apply("R1", 6'd0, 6'd32, 32'hffff_ffff, 32'h1, 16'h0);
    apply("R2", 6'd0, 6'd34, 32'h0, 32'h1, 16'h0);
    apply("R3", 6'd0, 6'd42, 32'h8000_0000, 32'h1, 16'h0);
    apply("R3", 6'd0, 6'd42, 32'h7fff_ffff, 32'hffff_ffff, 16'h0);
    apply("R3", 6'd0, 6'd42, 32'h5, 32'h5, 16'h0);
    apply("R4", 6'd0, 6'd39, 32'h0, 32'h0, 16'h0);
    apply("R5", 6'd13, 6'd0, 32'h1234_0000, 32'h0, 16'hffff);
    apply("R5", 6'd14, 6'd0, 32'hffff_ffff, 32'h0, 16'h8000);
    apply("R6", 6'd8, 6'd0, 32'h10, 32'h0, 16'h8000);
    apply("R6", 6'd8, 6'd0, 32'h10, 32'h0, 16'h7fff);
    apply("R6", 6'd10, 6'd0, 32'hffff_0000, 32'h0, 16'hffff);
    apply("R7", 6'd15, 6'd0, 32'hdead_beef, 32'h0, 16'h2110);
    apply("R8", 6'd0, 6'd33, 32'h3, 32'h4, 16'h0);
    apply("R8", 6'd9, 6'd32, 32'h3, 32'h4, 16'h5);
    apply("R9", 6'd0, 6'd34, 32'h8000_0000, 32'h8000_0000, 16'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] op, fn;
      logic [31:0] a, b;
      case ($urandom_range(0, 3))
        0: begin op = $urandom; fn = $urandom; end
        default: begin
          op = legal_op[$urandom_range(0, 6)];
          fn = legal_fn[$urandom_range(0, 6)];
        end
      endcase
      a = $urandom;
      b = ($urandom_range(0, 7) == 0) ? a : $urandom;
      if ($urandom_range(0, 5) == 0) a = {a[31], 31'h0} ^ {1'b0, b[30:0]};
      apply(tag_of(op, fn), op, fn, a, b, 16'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule